// File: doc/BRIEF.md
# Main-CPU memory mapping controller

This block holds the memory-mapping state of an 8-bit main processor with a Z80-style bus. Software sets two overlay enables and a two-bit bank number by writing a map port in the top four addresses of the I/O space. A second output port drives the bus-request and reset lines of a sub-processor. The other two ports in that group are read-only status ports. They return configuration switches and the sub-processor's acknowledge and ready flags. The whole low address byte is decoded, and the upper address byte is ignored during I/O cycles.

From the current memory address and the overlay enables, the block produces a gate for the row strobe of the base RAM. The gate closes only inside the window of an overlay that is switched on, and never while the special mode input is high. A wait generator requests one clock of WAIT at the start of each opcode fetch when its enable switch is on.

The DRAM timing itself and the handshake logic of the sub-processor are outside this block.

Top module: `mem_map_ctrl`

## Requirements
- R1: After reset, both overlay enables, the bank select and the sub-processor reset output are low. The sub-processor bus request is high, and `wait_n` is high.
- R2: A write to low address byte FD (iorq_n and wr_n low at a rising edge) loads the map register: bit 0 is overlay 1, bit 1 is overlay 2, bits 3:2 are the bank select. The upper address byte has no effect on the decode.
- R3: A write to low address byte FC loads the sub-processor control: bit 0 drives `sub_breq` and bit 1 drives `sub_rst`.
- R4: A write has no effect on any register in each of these cases: the low byte is outside FC–FD, the port is FE or FF, or iorq_n is high.
- R5: While iorq_n and rd_n are low with low byte FC, FD, FE or FF, `dout_en` is high and `dout` returns the following:
  - FC returns the sub-processor control bits, with bits 7:2 reading 0.
  - FD returns the map register, with bits 7:4 reading 0.
  - FE returns the switches in bits 4:0.
  - FF returns the acknowledge flag in bit 0 and the ready flag in bit 1.
  
  Otherwise `dout_en` is low and `dout` is 0.
- R6: With overlay 1 on and `sd_mode` low, `ram_ras_en` is low for addresses 4000–7FFF and high outside that window.
- R7: With overlay 2 on and `sd_mode` low, `ram_ras_en` is low for addresses 8000–BFFF and high outside that window.
- R8: While `sd_mode` is high, `ram_ras_en` is high for every address and overlay setting.
- R9: With `wait_en` high, `wait_n` goes low for exactly one clock. It does so in the cycle after the first rising edge at which m1_n and mreq_n are both low.
- R10: No further WAIT is requested until m1_n has returned high. No WAIT is requested when `wait_en` is low, or when m1_n is low while mreq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | CPU address bus |
| din | input | 8 | CPU write data |
| dout | output | 8 | Read data for the I/O ports |
| dout_en | output | 1 | High while `dout` should drive the data bus |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch strobe, active low |
| sd_mode | input | 1 | Special mode: disables the row-strobe blocking |
| wait_en | input | 1 | Switch that enables the fetch wait |
| sw | input | 5 | Configuration switches |
| sub_ack | input | 1 | Sub-processor acknowledge |
| sub_rdy | input | 1 | Sub-processor ready |
| ovl1_en | output | 1 | Overlay 1 enable (4000–7FFF) |
| ovl2_en | output | 1 | Overlay 2 enable (8000–BFFF) |
| bank_sel | output | 2 | Bank number for the 2000–3FFF window |
| sub_breq | output | 1 | Bus request to the sub-processor |
| sub_rst | output | 1 | Reset to the sub-processor |
| ram_ras_en | output | 1 | Row-strobe gate for the base RAM |
| wait_n | output | 1 | WAIT request, active low |

## Verification
A wrong map register appears on the overlay and bank outputs one clock after the write that caused it. It is also visible through a read of the map port in the same cycle as the read strobe, so corruption is caught before the next instruction. An error in the window arithmetic shows up on `ram_ras_en` within the same cycle, at the first address on either side of a window edge. A stale re-arm flag in the wait generator shows up as a missing or doubled WAIT clock on the next opcode fetch.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  typedef logic [7:0] port_t;

  localparam port_t PORT_SUB  = 8'hFC;
  localparam port_t PORT_MAP  = 8'hFD;
  localparam port_t PORT_SW   = 8'hFE;
  localparam port_t PORT_STAT = 8'hFF;

  typedef struct packed {
    logic [1:0] bank;
    logic       ovl2;
    logic       ovl1;
  } map_t;

  typedef struct packed {
    logic srst;
    logic breq;
  } sub_t;

  localparam map_t MAP_RST = '{bank: 2'b00, ovl2: 1'b0, ovl1: 1'b0};
  localparam sub_t SUB_RST = '{srst: 1'b0, breq: 1'b1};

  function automatic logic in_window(input logic [15:0] a,
                                     input logic [15:0] lo,
                                     input logic [15:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic ras_permitted(input logic mode, input logic ov1,
                                         input logic hit1, input logic ov2,
                                         input logic hit2);
    return mode || !((ov1 && hit1) || (ov2 && hit2));
  endfunction

endpackage

// File: rtl/mmap_regs.sv
module mmap_regs
  import mmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SW_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic [DATA_W-1:0] din,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [SW_W-1:0]   sw,
  input  logic              sub_ack,
  input  logic              sub_rdy,
  output map_t              map_q,
  output sub_t              sub_q,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int MAP_W = $bits(map_t);
  localparam int SUB_W = $bits(sub_t);

  logic wr_act, rd_act, map_wr, sub_wr, port_hit;

  assign wr_act   = !iorq_n && !wr_n;
  assign rd_act   = !iorq_n && !rd_n;
  assign map_wr   = wr_act && (io_addr == PORT_MAP);
  assign sub_wr   = wr_act && (io_addr == PORT_SUB);
  assign port_hit = (io_addr == PORT_SUB) || (io_addr == PORT_MAP) ||
                    (io_addr == PORT_SW)  || (io_addr == PORT_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= MAP_RST;
      sub_q <= SUB_RST;
    end else begin
      if (map_wr) map_q <= map_t'(din[MAP_W-1:0]);
      if (sub_wr) sub_q <= sub_t'(din[SUB_W-1:0]);
    end
  end

  always_comb begin
    dout = '0;
    if (rd_act) begin
      unique case (io_addr)
        PORT_SUB:  dout[SUB_W-1:0] = sub_q;
        PORT_MAP:  dout[MAP_W-1:0] = map_q;
        PORT_SW:   dout[SW_W-1:0]  = sw;
        PORT_STAT: dout[1:0]       = {sub_rdy, sub_ack};
        default:   dout            = '0;
      endcase
    end
  end

  assign dout_en = rd_act && port_hit;

  p_map_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !map_wr |=> $stable(map_q));
  p_sub_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_wr |=> $stable(sub_q));
  p_rd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |-> (!dout_en && dout == '0));

endmodule

// File: rtl/ovl_gate.sv
module ovl_gate
  import mmap_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] OV1_LO  = 16'h4000,
  parameter logic [15:0] OV1_HI  = 16'h7FFF,
  parameter logic [15:0] OV2_LO  = 16'h8000,
  parameter logic [15:0] OV2_HI  = 16'hBFFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  map_t              map_q,
  input  logic              sd_mode,
  output logic              hit1,
  output logic              hit2,
  output logic              ras_en
);
  assign hit1   = in_window(addr, OV1_LO, OV1_HI);
  assign hit2   = in_window(addr, OV2_LO, OV2_HI);
  assign ras_en = ras_permitted(sd_mode, map_q.ovl1, hit1, map_q.ovl2, hit2);
endmodule

// File: rtl/fetch_wait.sv
module fetch_wait (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  input  logic mreq_n,
  input  logic wait_en,
  output logic wait_n
);
  logic fetch, armed, start, wait_q;

  assign fetch = !m1_n && !mreq_n;
  assign start = fetch && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b1;
      wait_q <= 1'b0;
    end else begin
      wait_q <= start && wait_en;
      if (m1_n)       armed <= 1'b1;
      else if (start) armed <= 1'b0;
    end
  end

  assign wait_n = !wait_q;

  p_wait_one_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |=> !wait_q);
  p_wait_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> $past(fetch && wait_en));
  p_no_retrigger_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> $past(armed));

endmodule

// File: rtl/mem_map_ctrl.sv
module mem_map_ctrl
  import mmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SW_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic              sd_mode,
  input  logic              wait_en,
  input  logic [SW_W-1:0]   sw,
  input  logic              sub_ack,
  input  logic              sub_rdy,
  output logic              ovl1_en,
  output logic              ovl2_en,
  output logic [1:0]        bank_sel,
  output logic              sub_breq,
  output logic              sub_rst,
  output logic              ram_ras_en,
  output logic              wait_n
);
  map_t map_q;
  sub_t sub_q;
  logic hit1, hit2;

  mmap_regs #(.DATA_W(DATA_W), .SW_W(SW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(addr[7:0]), .din(din),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .sw(sw),
    .sub_ack(sub_ack), .sub_rdy(sub_rdy), .map_q(map_q), .sub_q(sub_q),
    .dout(dout), .dout_en(dout_en)
  );

  ovl_gate #(.ADDR_W(ADDR_W)) u_gate (
    .addr(addr), .map_q(map_q), .sd_mode(sd_mode),
    .hit1(hit1), .hit2(hit2), .ras_en(ram_ras_en)
  );

  fetch_wait u_wait (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .mreq_n(mreq_n),
    .wait_en(wait_en), .wait_n(wait_n)
  );

  assign ovl1_en  = map_q.ovl1;
  assign ovl2_en  = map_q.ovl2;
  assign bank_sel = map_q.bank;
  assign sub_breq = sub_q.breq;
  assign sub_rst  = sub_q.srst;

  p_gate_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ras_en |-> !sd_mode);
  p_gate_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_ras_en |-> ((ovl1_en && hit1) || (ovl2_en && hit2)));
  p_gate_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit1 && !hit2) |-> ram_ras_en);

endmodule

// File: tb/test_mem_map_ctrl.sv
module test_mem_map_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  din = 8'h00;
  logic [7:0]  dout;
  logic        dout_en;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic        sd_mode = 1'b0, wait_en = 1'b0;
  logic [4:0]  sw = 5'h00;
  logic        sub_ack = 1'b0, sub_rdy = 1'b0;
  logic        ovl1_en, ovl2_en, sub_breq, sub_rst, ram_ras_en, wait_n;
  logic [1:0]  bank_sel;

  always #4 clk = ~clk;

  mem_map_ctrl i_mem_map_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .sd_mode(sd_mode), .wait_en(wait_en),
    .sw(sw), .sub_ack(sub_ack), .sub_rdy(sub_rdy), .ovl1_en(ovl1_en),
    .ovl2_en(ovl2_en), .bank_sel(bank_sel), .sub_breq(sub_breq),
    .sub_rst(sub_rst), .ram_ras_en(ram_ras_en), .wait_n(wait_n)
  );

  // observation vector: [0]ovl1 [1]ovl2 [3:2]bank [4]breq [5]srst
  // [6]ras [7]wait_n [15:8]dout [16]dout_en
  logic [31:0] obs;
  assign obs = {15'b0, dout_en, dout, wait_n, ram_ras_en, sub_rst, sub_breq,
                bank_sel, ovl2_en, ovl1_en};

  localparam logic [31:0] M_MAP = 32'h0000_000F;
  localparam logic [31:0] M_SUB = 32'h0000_0030;
  localparam logic [31:0] M_RAS = 32'h0000_0040;
  localparam logic [31:0] M_WT  = 32'h0000_0080;
  localparam logic [31:0] M_RD  = 32'h0001_FF00;

  typedef struct {
    string       req;
    logic [31:0] mask;
    logic [31:0] exp;
  } item_t;

  item_t sb[$];
  event  sample_ev;
  int    compared = 0;
  int    mismatched = 0;
  bit    done = 1'b0;

  always @(sample_ev) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if ((obs & it.mask) !== (it.exp & it.mask)) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h (mask %h)", it.req,
                 obs & it.mask, it.exp & it.mask, it.mask);
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] m, input logic [31:0] e);
    sb.push_back('{req: r, mask: m, exp: e});
    -> sample_ev;
    #1;
  endtask

  function automatic logic [31:0] rd_exp(input logic [7:0] d);
    return {15'b0, 1'b1, d, 8'b0};
  endfunction

  function automatic logic [31:0] ras_exp(input logic r);
    return {25'b0, r, 6'b0};
  endfunction

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d, input logic io);
    @(negedge clk);
    addr = a; din = d; iorq_n = !io; wr_n = 1'b0;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1; addr = 16'h0000;
    #1;
  endtask

  task automatic io_rd_chk(input string r, input logic [15:0] a, input logic [31:0] e);
    @(negedge clk);
    addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    #1;
    chk(r, M_RD, e);
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic ras_chk(input string r, input logic [15:0] a, input logic e);
    addr = a;
    #1;
    chk(r, M_RAS, ras_exp(e));
  endtask

  // fetch lasting three clocks; expect wait pulse pattern p[0..2] (1 = wait_n low)
  task automatic fetch(input string r, input logic mq, input logic [2:0] p);
    @(negedge clk);
    m1_n = 1'b0; mreq_n = !mq;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      #1;
      chk(r, M_WT, {24'b0, !p[i], 7'b0});
    end
    m1_n = 1'b1; mreq_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset values
    chk("R1 map reset", M_MAP, 32'h0);
    chk("R1 sub reset", M_SUB, 32'h10);
    chk("R1 wait reset", M_WT, 32'h80);

    // R2 map write, upper address byte arbitrary
    io_wr(16'hA5FD, 8'h0D, 1'b1);
    chk("R2 map write", M_MAP, 32'hD);
    io_wr(16'h00FD, 8'hF9, 1'b1);
    chk("R2 map rewrite", M_MAP, 32'h9);
    io_rd_chk("R5 map readback zero high bits", 16'h12FD, rd_exp(8'h09));

    // R6 overlay 1 window edges
    ras_chk("R6 ovl1 low edge", 16'h4000, 1'b0);
    ras_chk("R6 ovl1 high edge", 16'h7FFF, 1'b0);
    ras_chk("R6 below window", 16'h3FFF, 1'b1);
    ras_chk("R6 above window", 16'h8000, 1'b1);

    // R8 special mode
    sd_mode = 1'b1;
    ras_chk("R8 mode ovl1 window", 16'h5000, 1'b1);
    sd_mode = 1'b0;

    // R7 overlay 2 window edges
    io_wr(16'h00FD, 8'h02, 1'b1);
    ras_chk("R7 ovl2 low edge", 16'h8000, 1'b0);
    ras_chk("R7 ovl2 high edge", 16'hBFFF, 1'b0);
    ras_chk("R7 ovl1 area open", 16'h4000, 1'b1);
    ras_chk("R7 above window", 16'hC000, 1'b1);
    io_wr(16'h00FD, 8'h03, 1'b1);
    sd_mode = 1'b1;
    ras_chk("R8 mode ovl2 window", 16'hA000, 1'b1);
    ras_chk("R8 mode ovl1 window both", 16'h6000, 1'b1);
    sd_mode = 1'b0;
    io_wr(16'h00FD, 8'h02, 1'b1);

    // R4 ignored writes
    io_wr(16'h00FB, 8'h0F, 1'b1);
    chk("R4 wrong port", M_MAP, 32'h2);
    io_wr(16'h00FD, 8'h0F, 1'b0);
    chk("R4 no iorq", M_MAP, 32'h2);
    io_wr(16'h00FE, 8'hFF, 1'b1);
    io_wr(16'h00FF, 8'hFF, 1'b1);
    chk("R4 read-only ports map", M_MAP, 32'h2);
    chk("R4 read-only ports sub", M_SUB, 32'h10);
    io_wr(16'h01FC, 8'h03, 1'b1);
    io_wr(16'h00FD, 8'h0C, 1'b0);
    chk("R4 no iorq map kept", M_MAP, 32'h2);

    // R3 sub-processor control
    io_wr(16'h00FC, 8'hFE, 1'b1);
    chk("R3 sub write", M_SUB, 32'h20);
    io_rd_chk("R5 sub readback", 16'h00FC, rd_exp(8'h02));
    io_wr(16'h00FC, 8'h01, 1'b1);
    chk("R3 sub rewrite", M_SUB, 32'h10);

    // R5 status reads
    sw = 5'h15;
    io_rd_chk("R5 switches", 16'h77FE, rd_exp(8'h15));
    sub_ack = 1'b1; sub_rdy = 1'b0;
    io_rd_chk("R5 ack flag", 16'h00FF, rd_exp(8'h01));
    sub_ack = 1'b0; sub_rdy = 1'b1;
    io_rd_chk("R5 ready flag", 16'h00FF, rd_exp(8'h02));
    io_rd_chk("R5 unmapped port", 16'h00FB, 32'h0);
    @(negedge clk);
    addr = 16'h00FD; rd_n = 1'b0;
    #1;
    chk("R5 read without iorq", M_RD, 32'h0);
    rd_n = 1'b1;

    // R9 / R10 wait generator
    wait_en = 1'b1;
    fetch("R9 single wait clock", 1'b1, 3'b001);
    fetch("R10 rearmed after m1 high", 1'b1, 3'b001);
    fetch("R10 m1 without mreq", 1'b0, 3'b000);
    wait_en = 1'b0;
    fetch("R10 wait disabled", 1'b1, 3'b000);

    done = 1'b1;
    report();
  end
endmodule